// File: doc/BRIEF.md
# Companion Clock Wake Sequencer

This block brings an attached companion device from reset into a fully clocked state and later lets it drop into a low-power doze. Software drives it through a small register port. A control register holds five bits: VCO off, PLL bypass, output enable, run-clock enable and ready enable. A memory-configuration register and a read-only identity register sit beside it. A per-function clock-enable register gates the device's function clocks.

Clearing VCO off starts a lock wait. The PLL is modelled as a countdown of `LOCK_CYC` cycles. Once lock is reached and run-clock enable is set, the block counts `SETTLE_CYC` run-clock cycles and then raises `ready_o`. A run-clock enable written before lock completes is stored but takes effect only when lock completes. Until the device is ready, the per-function register is fenced off.

A doze request is refused while the USB function clock is enabled. Otherwise the request clears run-clock enable and drops ready.

The state machine has six states. SEQ_OFF is the VCO off state. SEQ_LOCK is the lock wait. SEQ_LOCKED means locked and waiting for run-clock enable. SEQ_SETTLE counts the settle cycles. SEQ_READY is awake. SEQ_DOZE is dozing.

The transitions are:
- OFF to LOCK when VCO off is cleared.
- LOCK to SETTLE when the lock count ends with run-clock enable set, or LOCK to LOCKED when it ends with that bit clear.
- LOCKED to SETTLE when run-clock enable is set.
- SETTLE to READY when the settle count ends.
- SETTLE to LOCKED when run-clock enable is cleared.
- READY to DOZE on an accepted doze request or when run-clock enable is cleared.
- DOZE to SETTLE when run-clock enable is set again.
- Any state to OFF when VCO off is set.

Top module: `clkwake_seq`

## Requirements
- R1: After reset `ready_o` is low, `access_err_o` and `doze_nack_o` are low, and the control register (address 0) reads 1. Its bits are [0] VCO off, [1] PLL bypass, [2] output enable, [3] run-clock enable and [4] ready enable; the reset value has VCO off set and all other bits clear.
- R2: When a single write to the control register clears VCO off and sets run-clock enable at edge W, `ready_o` stays low through edge W+LOCK_CYC+14 and is high after edge W+LOCK_CYC+15. The early run-clock enable is therefore held off until lock completes.
- R3: When lock has already completed, a write setting run-clock enable at edge W raises `ready_o` after edge W+SETTLE_CYC+1 and not before. This is one cycle for the register plus the settle count.
- R4: While the device is not ready, any access to the per-function register (address 3) returns 0 on `rd_data_o`, leaves the register unchanged, and pulses `access_err_o` for one cycle.
- R5: Addresses 0, 1 and 2 are accessible in every state without raising `access_err_o`. Read data appears on `rd_data_o` in the cycle after the request edge. The memory-configuration register (address 1) is a full-width read/write register.
- R6: The identity register (address 2) reads `{DEV_ID, SI_REV, MT_REV}`, with the silicon revision in bits [7:4] and the metal revision in bits [3:0]. Writes to it have no effect.
- R7: On entry to the ready state the per-function register is cleared to zero.
- R8: When `doze_req_i` is sampled in the ready state with per-function bit `USB_BIT` (default 0) set, `doze_nack_o` pulses, `ready_o` stays high and run-clock enable stays set.
- R9: When `doze_req_i` is sampled in the ready state with `USB_BIT` clear, `ready_o` is low from the next cycle and run-clock enable reads 0.
- R10: Setting run-clock enable while dozing raises `ready_o` after SETTLE_CYC+1 cycles again, with no new lock wait.
- R11: Setting VCO off in the ready state drops `ready_o` one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the run clock is taken to be this clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | DATA_W | Write data |
| doze_req_i | input | 1 | Doze request, sampled each cycle |
| rd_data_o | output | DATA_W | Read data, one cycle after the request |
| access_err_o | output | 1 | One-cycle pulse on a fenced access |
| doze_nack_o | output | 1 | One-cycle pulse on a refused doze |
| ready_o | output | 1 | Device awake and clocked |

## Verification
The hardest case to reach from the ports is the held-off run-clock enable. It needs the enable to be written in the same access that starts the lock wait, so that the bit is already set while the lock counter is still running. The bench writes both fields in one access. It then counts edges to show that `ready_o` rises only after the full lock time plus the settle count. Proving that the per-function register is cleared on wake also needs a prior non-zero value, which can only be written while awake. The bench therefore sets that value, dozes, wakes again and reads the register back.

// File: rtl/clkwake_pkg.sv
package clkwake_pkg;
    typedef enum logic [2:0] {
        SEQ_OFF,
        SEQ_LOCK,
        SEQ_LOCKED,
        SEQ_SETTLE,
        SEQ_READY,
        SEQ_DOZE
    } seq_state_e;

    localparam int CTL_VCO_OFF = 0;
    localparam int CTL_BYPASS  = 1;
    localparam int CTL_OUT_EN  = 2;
    localparam int CTL_RCLK_EN = 3;
    localparam int CTL_RDY_EN  = 4;
    localparam int CTL_W       = 5;

    localparam logic [1:0] ADR_CTRL   = 2'd0;
    localparam logic [1:0] ADR_MEMCFG = 2'd1;
    localparam logic [1:0] ADR_IDENT  = 2'd2;
    localparam logic [1:0] ADR_FNCLK  = 2'd3;
endpackage

// File: rtl/clkwake_countdown.sv
module clkwake_countdown #(
    parameter int LIMIT = 14
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic en_i,
    output logic zero_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] START = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= START;
        else if (en_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/clkwake_regs.sv
module clkwake_regs
    import clkwake_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter int                FNCLK_W = 8,
    parameter logic [DATA_W-9:0] DEV_ID = '0,
    parameter logic [3:0]        SI_REV = 4'h0,
    parameter logic [3:0]        MT_REV = 4'h0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_i,
    input  logic               we_i,
    input  logic [1:0]         addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               awake_i,
    input  logic               clr_fnclk_i,
    input  logic               clr_rclk_i,
    output logic [CTL_W-1:0]   ctrl_o,
    output logic [FNCLK_W-1:0] fnclk_o,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               err_o
);
    localparam logic [CTL_W-1:0] CTRL_RST = CTL_W'(1) << CTL_VCO_OFF;

    logic [CTL_W-1:0]   ctrl_q;
    logic [DATA_W-1:0]  memcfg_q;
    logic [FNCLK_W-1:0] fnclk_q;
    logic               fenced;
    logic [DATA_W-1:0]  rd_mux;

    assign fenced = req_i && (addr_i == ADR_FNCLK) && !awake_i;

    always_comb begin
        unique case (addr_i)
            ADR_CTRL:   rd_mux = DATA_W'(ctrl_q);
            ADR_MEMCFG: rd_mux = memcfg_q;
            ADR_IDENT:  rd_mux = {DEV_ID, SI_REV, MT_REV};
            ADR_FNCLK:  rd_mux = DATA_W'(fnclk_q);
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q    <= CTRL_RST;
            memcfg_q  <= '0;
            fnclk_q   <= '0;
            rd_data_o <= '0;
            err_o     <= 1'b0;
        end else begin
            err_o     <= fenced;
            rd_data_o <= (req_i && !we_i && !fenced) ? rd_mux : '0;
            if (req_i && we_i) begin
                if (addr_i == ADR_CTRL)   ctrl_q   <= wdata_i[CTL_W-1:0];
                if (addr_i == ADR_MEMCFG) memcfg_q <= wdata_i;
                if (addr_i == ADR_FNCLK && awake_i) fnclk_q <= wdata_i[FNCLK_W-1:0];
            end
            if (clr_rclk_i)  ctrl_q[CTL_RCLK_EN] <= 1'b0;
            if (clr_fnclk_i) fnclk_q <= '0;
        end
    end

    assign ctrl_o  = ctrl_q;
    assign fnclk_o = fnclk_q;
endmodule

// File: rtl/clkwake_seq.sv
module clkwake_seq
    import clkwake_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter int                FNCLK_W    = 8,
    parameter int                USB_BIT    = 0,
    parameter int                LOCK_CYC   = 5000,
    parameter int                SETTLE_CYC = 14,
    parameter logic [DATA_W-9:0] DEV_ID     = 24'hC0A11E,
    parameter logic [3:0]        SI_REV     = 4'h2,
    parameter logic [3:0]        MT_REV     = 4'h1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              doze_req_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              access_err_o,
    output logic              doze_nack_o,
    output logic              ready_o
);
    seq_state_e         st_q, st_d;
    logic [CTL_W-1:0]   ctrl_q;
    logic [FNCLK_W-1:0] fnclk_q;
    logic               lock_zero, settle_zero;
    logic               vco_off, rclk_en, usb_on;
    logic               doze_go, doze_refuse;

    assign vco_off     = ctrl_q[CTL_VCO_OFF];
    assign rclk_en     = ctrl_q[CTL_RCLK_EN];
    assign usb_on      = fnclk_q[USB_BIT];
    assign doze_go     = (st_q == SEQ_READY) && doze_req_i && !usb_on;
    assign doze_refuse = (st_q == SEQ_READY) && doze_req_i && usb_on;

    clkwake_regs #(
        .DATA_W(DATA_W), .FNCLK_W(FNCLK_W),
        .DEV_ID(DEV_ID), .SI_REV(SI_REV), .MT_REV(MT_REV)
    ) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .awake_i(st_q == SEQ_READY),
        .clr_fnclk_i(st_q != SEQ_READY && st_d == SEQ_READY),
        .clr_rclk_i(doze_go),
        .ctrl_o(ctrl_q), .fnclk_o(fnclk_q),
        .rd_data_o(rd_data_o), .err_o(access_err_o)
    );

    clkwake_countdown #(.LIMIT(LOCK_CYC)) u_lock (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .load_i(st_q != SEQ_LOCK && st_d == SEQ_LOCK),
        .en_i(st_q == SEQ_LOCK),
        .zero_o(lock_zero)
    );

    clkwake_countdown #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .load_i(st_q != SEQ_SETTLE && st_d == SEQ_SETTLE),
        .en_i(st_q == SEQ_SETTLE),
        .zero_o(settle_zero)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= SEQ_OFF;
        else         st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_OFF:    if (!vco_off) st_d = SEQ_LOCK;
            SEQ_LOCK:   if (vco_off) st_d = SEQ_OFF;
                        else if (lock_zero) st_d = rclk_en ? SEQ_SETTLE : SEQ_LOCKED;
            SEQ_LOCKED: if (vco_off) st_d = SEQ_OFF;
                        else if (rclk_en) st_d = SEQ_SETTLE;
            SEQ_SETTLE: if (vco_off) st_d = SEQ_OFF;
                        else if (!rclk_en) st_d = SEQ_LOCKED;
                        else if (settle_zero) st_d = SEQ_READY;
            SEQ_READY:  if (vco_off) st_d = SEQ_OFF;
                        else if (doze_go || !rclk_en) st_d = SEQ_DOZE;
            SEQ_DOZE:   if (vco_off) st_d = SEQ_OFF;
                        else if (rclk_en) st_d = SEQ_SETTLE;
            default:    st_d = SEQ_OFF;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) doze_nack_o <= 1'b0;
        else         doze_nack_o <= doze_refuse;
    end

    assign ready_o = (st_q == SEQ_READY);
endmodule

// File: rtl/clkwake_chk.sv
module clkwake_chk
    import clkwake_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int FNCLK_W = 8,
    parameter int USB_BIT = 0
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               req_i,
    input logic [1:0]         addr_i,
    input logic [DATA_W-1:0]  rd_data_o,
    input logic               access_err_o,
    input logic               doze_nack_o,
    input logic               ready_o,
    input logic [CTL_W-1:0]   ctrl_q,
    input logic [FNCLK_W-1:0] fnclk_q
);
    assert_err_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        access_err_o |-> $past(req_i && addr_i == ADR_FNCLK));

    assert_err_reads_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        access_err_o |-> rd_data_o == '0);

    assert_wake_clears_fnclk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ready_o) |-> fnclk_q == '0);

    assert_wake_needs_rclk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ready_o) |-> ctrl_q[CTL_RCLK_EN] && !ctrl_q[CTL_VCO_OFF]);

    assert_refuse_keeps_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        doze_nack_o |-> ready_o && ctrl_q[CTL_RCLK_EN]);

    assert_refuse_needs_usb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        doze_nack_o |-> $past(fnclk_q[USB_BIT]));

    assert_sleep_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ready_o) |-> !ctrl_q[CTL_RCLK_EN] || ctrl_q[CTL_VCO_OFF]);
endmodule

bind clkwake_seq clkwake_chk #(
    .DATA_W(DATA_W), .FNCLK_W(FNCLK_W), .USB_BIT(USB_BIT)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
    .rd_data_o(rd_data_o), .access_err_o(access_err_o),
    .doze_nack_o(doze_nack_o), .ready_o(ready_o),
    .ctrl_q(ctrl_q), .fnclk_q(fnclk_q)
);

// File: tb/clkwake_seq_bench.sv
module clkwake_seq_bench;
    localparam int LOCK = 20;
    localparam int SETTLE = 14;
    localparam logic [23:0] DID = 24'hC0A11E;
    localparam logic [31:0] IDV = {DID, 4'h2, 4'h1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, doze = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd;
    logic        err, nack, ready;
    int          n_chk = 0, n_fail = 0;
    logic [31:0] r_rd;
    logic        r_err;

    always #10 clk = ~clk;

    clkwake_seq #(.LOCK_CYC(LOCK), .SETTLE_CYC(SETTLE), .DEV_ID(DID),
                  .SI_REV(4'h2), .MT_REV(4'h1)) u_clkwake_seq (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .doze_req_i(doze), .rd_data_o(rd),
        .access_err_o(err), .doze_nack_o(nack), .ready_o(ready));

    // {we, addr, wdata, expected rd, expected err}, all in the ready state
    typedef struct packed {
        logic        w;
        logic [1:0]  a;
        logic [31:0] d;
        logic [31:0] e_rd;
        logic        e_err;
    } vec_t;
    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{1'b1, 2'd1, 32'hA5A5_0F0F, 32'h0, 1'b0},
        '{1'b0, 2'd1, 32'h0,         32'hA5A5_0F0F, 1'b0},
        '{1'b1, 2'd2, 32'hFFFF_FFFF, 32'h0, 1'b0},
        '{1'b0, 2'd2, 32'h0,         IDV, 1'b0},
        '{1'b0, 2'd0, 32'h0,         32'h0000_001E, 1'b0},
        '{1'b1, 2'd3, 32'h0000_0006, 32'h0, 1'b0},
        '{1'b0, 2'd3, 32'h0,         32'h0000_0006, 1'b0},
        '{1'b0, 2'd1, 32'h0,         32'hA5A5_0F0F, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        r_rd = rd; r_err = err;
    endtask

    task automatic pulse_doze();
        @(negedge clk);
        doze = 1'b1;
        @(posedge clk);
        @(negedge clk);
        doze = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        check("R1 ready", 32'(ready), 0);
        check("R1 err", 32'(err), 0);
        check("R1 nack", 32'(nack), 0);
        access(1'b0, 2'd0, 0);
        check("R1 ctrl reset", r_rd, 32'h1);
        // R4 fenced access before ready
        access(1'b1, 2'd3, 32'hFF);
        check("R4 write err", 32'(r_err), 1);
        access(1'b0, 2'd3, 0);
        check("R4 read err", 32'(r_err), 1);
        check("R4 read zero", r_rd, 0);
        @(negedge clk);
        check("R4 err one cycle", 32'(err), 0);
        // R5 / R6 open registers before ready
        access(1'b1, 2'd1, 32'h1234_5678);
        check("R5 write no err", 32'(r_err), 0);
        access(1'b0, 2'd1, 0);
        check("R5 memcfg", r_rd, 32'h1234_5678);
        access(1'b0, 2'd2, 0);
        check("R6 ident", r_rd, IDV);
        check("R5 ident no err", 32'(r_err), 0);
        // R2 lock wait with early run-clock enable
        access(1'b1, 2'd0, 32'h1E);
        wait_edges(LOCK + 13);
        check("R2 held off", 32'(ready), 0);
        wait_edges(1);
        check("R2 not yet", 32'(ready), 0);
        wait_edges(1);
        check("R2 ready", 32'(ready), 1);
        // R7 clear on wake
        access(1'b0, 2'd3, 0);
        check("R7 fnclk zero", r_rd, 0);
        check("R5 fnclk open", 32'(r_err), 0);
        // R5 / R6 vector table
        for (int i = 0; i < NV; i++) begin
            access(VT[i].w, VT[i].a, VT[i].d);
            if (!VT[i].w) check($sformatf("R5 vec%0d rd", i), r_rd, VT[i].e_rd);
            check($sformatf("R5 vec%0d err", i), 32'(r_err), 32'(VT[i].e_err));
        end
        // R8 refused doze
        access(1'b1, 2'd3, 32'h07);
        pulse_doze();
        check("R8 nack", 32'(nack), 1);
        check("R8 ready kept", 32'(ready), 1);
        access(1'b0, 2'd0, 0);
        check("R8 rclk kept", r_rd, 32'h1E);
        // R9 accepted doze
        access(1'b1, 2'd3, 32'h06);
        pulse_doze();
        check("R9 ready low", 32'(ready), 0);
        check("R9 no nack", 32'(nack), 0);
        access(1'b0, 2'd0, 0);
        check("R9 rclk cleared", r_rd, 32'h16);
        // R10 re-wake from doze, R3 settle count
        access(1'b1, 2'd0, 32'h1E);
        wait_edges(SETTLE);
        check("R3 R10 not yet", 32'(ready), 0);
        wait_edges(1);
        check("R3 R10 ready", 32'(ready), 1);
        access(1'b0, 2'd3, 0);
        check("R7 fnclk cleared on rewake", r_rd, 0);
        // R11 VCO off drops ready
        access(1'b1, 2'd0, 32'h1F);
        wait_edges(1);
        check("R11 ready low", 32'(ready), 0);
        access(1'b0, 2'd3, 0);
        check("R11 fnclk fenced", 32'(r_err), 1);
        // R1 reset while active
        access(1'b1, 2'd0, 32'h1E);
        wait_edges(LOCK + SETTLE + 2);
        check("R2 ready again", 32'(ready), 1);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk); rst_n = 1'b1;
        check("R1 ready after reset", 32'(ready), 0);
        access(1'b0, 2'd0, 0);
        check("R1 ctrl after reset", r_rd, 32'h1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule